// File: doc/BRIEF.md
# Low-Power Domain Real-Time Clock Registers

This block is a bus-facing real-time clock whose timekeeping lives in a slow, always-on domain. A 47-bit counter advances on a 32 kHz tick. Its upper 32 bits count whole seconds and its lower 15 bits count fractions of a second. A second 47-bit register holds an alarm time. The bus reaches the counter, the alarm, a control word, a status word and an interrupt-enable word through a small address/strobe interface.

Most writes do not take effect at once. The write is parked in a single pending slot and is committed on the next slow tick. That commit raises a completion flag, which the next status read consumes. The status word shows a busy indication for the whole wait. A second write that arrives during the wait is dropped and flagged as an error. Only the interrupt-enable word bypasses this path and changes in the next bus cycle.

The counter runs only when three conditions hold: software has enabled it, its seconds word has been written at least once, and the external failure indication is low. A single level interrupt combines every enabled status flag.

Top module: `lp_rtc_regs`

## Requirements
- R1: After reset the counter reads 0, the alarm reads all ones in both words, control and interrupt-enable read 0, status reads 0x0000_0202 (non-valid bit 1 and write-next bit 9 only), and irq is low.
- R2: A write to any address except 0x18 is held pending and committed on the first cycle that slow_tick is high. Status bit 10 (busy) is 1 from the cycle after the write until the commit. Status bit 9 (write-next) is always the inverse of bit 10.
- R3: Each commit sets status bit 8 (write complete). A read of status (0x14) clears bit 8 unless a commit happens in that same cycle.
- R4: A write to any address except 0x18 while busy is discarded and sets status bit 7 (write error).
- R5: A write to 0x18 updates the interrupt-enable word in the next cycle, keeping only bits 9, 8, 7, 4 and 0. It neither sets busy nor causes a commit.
- R6: A committed write to 0x00 loads counter bits 46:15 and keeps the fraction. A committed write to 0x04 loads bits 14:0. Reads of 0x00 and 0x04 return these fields. Each counting tick adds one, and the counter wraps from all ones to zero.
- R7: The counter advances only on ticks where control bit 3 (at 0x10) is 1, the seconds word has been committed at least once since reset, and fail_hold is low. While fail_hold is high, status bit 0 is set.
- R8: The alarm seconds (0x08) and alarm fraction (0x0C) words form a 47-bit alarm. When a counting tick moves the counter onto that value, status bit 4 is set.
- R9: A committed write to 0x14 clears each of status bits 7, 4, 1 and 0 that has a 1 in the written data. A set event in the same cycle takes priority over the clear.
- R10: irq is high exactly when some status bit among 9, 8, 7, 4 and 0 is 1 together with the same interrupt-enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse per 32 kHz period |
| fail_hold | input | 1 | Failure-state indication from the tamper logic |
| addr | input | 8 | Byte address of the register access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data for addr (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The counter is exercised in four situations: held by a disabled control bit, held by a never-written seconds word, held by fail_hold, and free-running. Comparing these separates the three gating terms from one another. Fraction loads near the 15-bit boundary show whether the carry reaches the seconds field. A load of all ones shows whether the full counter wraps. The write path is tried both with one write per tick and with back-to-back writes, which separates a correct commit from a dropped write with an error flag. Status reads are made both right after a commit and again with no commit between them, which shows that the complete flag is consumed by a read. Interrupt masks are changed between alarm, write-next and violation flags so that each enable bit is seen gating its own flag.

// File: rtl/lp_rtc_pkg.sv
package lp_rtc_pkg;
    // register byte offsets
    localparam int OFF_SEC   = 'h00;
    localparam int OFF_FRAC  = 'h04;
    localparam int OFF_ASEC  = 'h08;
    localparam int OFF_AFRAC = 'h0C;
    localparam int OFF_CTRL  = 'h10;
    localparam int OFF_STS   = 'h14;
    localparam int OFF_IER   = 'h18;

    // status / enable bit positions
    localparam int B_BUSY = 10;
    localparam int B_WNF  = 9;
    localparam int B_WCF  = 8;
    localparam int B_WEF  = 7;
    localparam int B_CAF  = 4;
    localparam int B_NVF  = 1;
    localparam int B_SVF  = 0;

    // control bit: counter enable
    localparam int B_EN = 3;
endpackage

// File: rtl/lp_rtc_wsync.sv
module lp_rtc_wsync #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              apply,
    output logic [ADDR_W-1:0] ap_addr,
    output logic [DATA_W-1:0] ap_data,
    output logic              busy,
    output logic              err
);
    typedef struct packed {
        logic              pend;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        apply  = slow_tick && slot_q.pend;
        err    = req && slot_q.pend;
        if (apply) begin
            slot_d.pend = 1'b0;
        end
        if (req && !slot_q.pend) begin
            slot_d.pend = 1'b1;
            slot_d.addr = req_addr;
            slot_d.data = req_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign ap_addr = slot_q.addr;
    assign ap_data = slot_q.data;
    assign busy    = slot_q.pend;
endmodule

// File: rtl/lp_rtc_counter.sv
module lp_rtc_counter #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15,
    localparam int CNT_W = SEC_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             enable,
    input  logic             hold,
    input  logic             ld_sec,
    input  logic             ld_frac,
    input  logic             ld_asec,
    input  logic             ld_afrac,
    input  logic [SEC_W-1:0] ld_data,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] alarm,
    output logic             alarm_hit
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] alarm;
        logic             written;
    } tc_t;

    tc_t tc_d, tc_q;
    logic run;

    always_comb begin
        tc_d      = tc_q;
        alarm_hit = 1'b0;
        run       = slow_tick && enable && tc_q.written && !hold;
        if (ld_sec) begin
            tc_d.cnt[CNT_W-1:FRAC_W] = ld_data;
            tc_d.written             = 1'b1;
        end else if (ld_frac) begin
            tc_d.cnt[FRAC_W-1:0] = ld_data[FRAC_W-1:0];
        end else if (run) begin
            tc_d.cnt  = tc_q.cnt + 1'b1;
            alarm_hit = (tc_d.cnt == tc_q.alarm);
        end
        if (ld_asec) begin
            tc_d.alarm[CNT_W-1:FRAC_W] = ld_data;
        end
        if (ld_afrac) begin
            tc_d.alarm[FRAC_W-1:0] = ld_data[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_q.cnt     <= '0;
            tc_q.alarm   <= '1;
            tc_q.written <= 1'b0;
        end else begin
            tc_q <= tc_d;
        end
    end

    assign cnt   = tc_q.cnt;
    assign alarm = tc_q.alarm;
endmodule

// File: rtl/lp_rtc_regs.sv
module lp_rtc_regs
    import lp_rtc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              fail_hold,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int CNT_W = SEC_W + FRAC_W;
    localparam logic [DATA_W-1:0] IER_MASK =
        DATA_W'((1 << B_WNF) | (1 << B_WCF) | (1 << B_WEF) | (1 << B_CAF) | (1 << B_SVF));

    typedef struct packed {
        logic              en;
        logic              wcf;
        logic              wef;
        logic              caf;
        logic              nvf;
        logic              svf;
        logic [DATA_W-1:0] ier;
    } reg_t;

    reg_t r_d, r_q;

    logic              wr_req, apply, busy, err, alarm_hit;
    logic [ADDR_W-1:0] ap_addr;
    logic [DATA_W-1:0] ap_data;
    logic [CNT_W-1:0]  cnt, alarm;
    logic [DATA_W-1:0] sts;
    logic              ap_sec, ap_frac, ap_asec, ap_afrac, ap_ctrl, ap_sts;

    assign wr_req = wr_en && (addr != ADDR_W'(OFF_IER));

    lp_rtc_wsync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wsync (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_tick(slow_tick),
        .req      (wr_req),
        .req_addr (addr),
        .req_data (wdata),
        .apply    (apply),
        .ap_addr  (ap_addr),
        .ap_data  (ap_data),
        .busy     (busy),
        .err      (err)
    );

    assign ap_sec   = apply && (ap_addr == ADDR_W'(OFF_SEC));
    assign ap_frac  = apply && (ap_addr == ADDR_W'(OFF_FRAC));
    assign ap_asec  = apply && (ap_addr == ADDR_W'(OFF_ASEC));
    assign ap_afrac = apply && (ap_addr == ADDR_W'(OFF_AFRAC));
    assign ap_ctrl  = apply && (ap_addr == ADDR_W'(OFF_CTRL));
    assign ap_sts   = apply && (ap_addr == ADDR_W'(OFF_STS));

    lp_rtc_counter #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_tick(slow_tick),
        .enable   (r_q.en),
        .hold     (fail_hold),
        .ld_sec   (ap_sec),
        .ld_frac  (ap_frac),
        .ld_asec  (ap_asec),
        .ld_afrac (ap_afrac),
        .ld_data  (ap_data[SEC_W-1:0]),
        .cnt      (cnt),
        .alarm    (alarm),
        .alarm_hit(alarm_hit)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en && (addr == ADDR_W'(OFF_IER))) begin
            r_d.ier = wdata & IER_MASK;
        end
        if (ap_ctrl) begin
            r_d.en = ap_data[B_EN];
        end
        // write-one-to-clear, then set events override
        if (ap_sts) begin
            if (ap_data[B_WEF]) r_d.wef = 1'b0;
            if (ap_data[B_CAF]) r_d.caf = 1'b0;
            if (ap_data[B_NVF]) r_d.nvf = 1'b0;
            if (ap_data[B_SVF]) r_d.svf = 1'b0;
        end
        if (rd_en && (addr == ADDR_W'(OFF_STS))) begin
            r_d.wcf = 1'b0;
        end
        if (apply)     r_d.wcf = 1'b1;
        if (err)       r_d.wef = 1'b1;
        if (alarm_hit) r_d.caf = 1'b1;
        if (fail_hold) r_d.svf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.nvf <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        sts         = '0;
        sts[B_BUSY] = busy;
        sts[B_WNF]  = !busy;
        sts[B_WCF]  = r_q.wcf;
        sts[B_WEF]  = r_q.wef;
        sts[B_CAF]  = r_q.caf;
        sts[B_NVF]  = r_q.nvf;
        sts[B_SVF]  = r_q.svf;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFF_SEC):   rdata = DATA_W'(cnt[CNT_W-1:FRAC_W]);
            ADDR_W'(OFF_FRAC):  rdata = DATA_W'(cnt[FRAC_W-1:0]);
            ADDR_W'(OFF_ASEC):  rdata = DATA_W'(alarm[CNT_W-1:FRAC_W]);
            ADDR_W'(OFF_AFRAC): rdata = DATA_W'(alarm[FRAC_W-1:0]);
            ADDR_W'(OFF_CTRL):  rdata[B_EN] = r_q.en;
            ADDR_W'(OFF_STS):   rdata = sts;
            ADDR_W'(OFF_IER):   rdata = r_q.ier;
            default:            rdata = '0;
        endcase
    end

    assign irq = |(sts & r_q.ier);
endmodule

// File: rtl/lp_rtc_chk.sv
module lp_rtc_chk
    import lp_rtc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 47
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slow_tick,
    input logic              fail_hold,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              wr_en,
    input logic              rd_en,
    input logic              busy,
    input logic [DATA_W-1:0] sts,
    input logic [DATA_W-1:0] ier,
    input logic [CNT_W-1:0]  cnt,
    input logic              irq
);
    logic is_ier;
    assign is_ier = (addr == ADDR_W'(OFF_IER));

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !is_ier && !busy |=> busy);

    // R2
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(slow_tick));

    // R3
    wcf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (addr == ADDR_W'(OFF_STS)) && !slow_tick |=> !sts[B_WCF]);

    // R4
    busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !is_ier && busy |=> sts[B_WEF]);

    // R5
    ier_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && is_ier |=> (ier[B_CAF] == $past(wdata[B_CAF])) && (ier[2] == 1'b0));

    // R6
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slow_tick |=> $stable(cnt));

    // R7
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_hold && !busy |=> $stable(cnt));

    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier == '0) |-> !irq);
endmodule

bind lp_rtc_regs lp_rtc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_tick(slow_tick),
    .fail_hold(fail_hold),
    .addr     (addr),
    .wdata    (wdata),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .busy     (busy),
    .sts      (sts),
    .ier      (r_q.ier),
    .cnt      (cnt),
    .irq      (irq)
);

// File: tb/lp_rtc_regs_tb.sv
module lp_rtc_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        fail_hold = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lp_rtc_regs u_dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fail_hold(fail_hold),
        .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
        .rdata(rdata), .irq(irq)
    );

    // behavioural reference state
    localparam longint M47 = (64'd1 << 47) - 1;
    longint m_cnt, m_asec, m_afrac, m_pdata;
    int     m_paddr;
    bit     m_en, m_wr, m_pend, m_wcf, m_wef, m_caf, m_nvf, m_svf;
    longint m_ier;

    function automatic longint m_sts();
        return (longint'(m_pend) << 10) | (longint'(!m_pend) << 9) | (longint'(m_wcf) << 8) |
               (longint'(m_wef) << 7) | (longint'(m_caf) << 4) | (longint'(m_nvf) << 1) |
               longint'(m_svf);
    endfunction

    function automatic longint m_read(input int a);
        case (a)
            'h00: return (m_cnt >> 15) & 64'hFFFF_FFFF;
            'h04: return m_cnt & 64'h7FFF;
            'h08: return m_asec;
            'h0C: return m_afrac;
            'h10: return longint'(m_en) << 3;
            'h14: return m_sts();
            'h18: return m_ier;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_asec = 64'hFFFF_FFFF; m_afrac = 64'h7FFF;
            m_en = 0; m_wr = 0; m_pend = 0; m_paddr = 0; m_pdata = 0;
            m_wcf = 0; m_wef = 0; m_caf = 0; m_nvf = 1; m_svf = 0; m_ier = 0;
        end else begin
            bit ap, run, hit, err, acc;
            int pa;
            longint pd;
            ap  = slow_tick && m_pend;
            pa  = m_paddr;
            pd  = m_pdata;
            run = slow_tick && m_en && m_wr && !fail_hold;
            err = wr_en && (addr != 8'h18) && m_pend;
            acc = wr_en && (addr != 8'h18) && !m_pend;
            hit = 0;
            if (ap && pa == 'h00) begin
                m_cnt = (pd << 15) | (m_cnt & 64'h7FFF);
                m_wr = 1;
            end else if (ap && pa == 'h04) begin
                m_cnt = (m_cnt & ~64'h7FFF) | (pd & 64'h7FFF);
            end else if (run) begin
                m_cnt = (m_cnt + 1) & M47;
                hit = (m_cnt == ((m_asec << 15) | m_afrac));
            end
            if (ap && pa == 'h08) m_asec = pd;
            if (ap && pa == 'h0C) m_afrac = pd & 64'h7FFF;
            if (ap && pa == 'h10) m_en = pd[3];
            if (wr_en && addr == 8'h18) m_ier = longint'(wdata) & 64'h391;
            if (ap && pa == 'h14) begin
                if (pd[7]) m_wef = 0;
                if (pd[4]) m_caf = 0;
                if (pd[1]) m_nvf = 0;
                if (pd[0]) m_svf = 0;
            end
            if (rd_en && addr == 8'h14) m_wcf = 0;
            if (ap) m_wcf = 1;
            if (err) m_wef = 1;
            if (hit) m_caf = 1;
            if (fail_hold) m_svf = 1;
            if (ap) m_pend = 0;
            if (acc) begin
                m_pend = 1; m_paddr = int'(addr); m_pdata = longint'(wdata);
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one bus cycle: drive away from the edge, then compare outputs
    task automatic step(input bit tk, input bit w, input bit r, input logic [7:0] a,
                        input logic [31:0] d, input string req);
        @(negedge clk);
        slow_tick = tk; wr_en = w; rd_en = r; addr = a; wdata = d;
        #1;
        if (r) check(longint'(rdata) == m_read(int'(a)), req, longint'(rdata), m_read(int'(a)));
        // R10: interrupt compared on every clock
        check(irq == ((m_sts() & m_ier) != 0), "R10", longint'(irq), longint'((m_sts() & m_ier) != 0));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00, 0, "R10");
    endtask

    task automatic ticks(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            step(1, 0, 0, 8'h00, 0, req);
            step(0, 0, 0, 8'h00, 0, req);
        end
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        step(0, 0, 1, a, 0, req);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(0, 1, 0, a, d, "R2");
        step(1, 0, 0, 8'h00, 0, "R2");
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'h00, "R1"); rd(8'h04, "R1"); rd(8'h08, "R1"); rd(8'h0C, "R1");
        rd(8'h10, "R1"); rd(8'h14, "R1"); rd(8'h18, "R1");

        // R2 busy while pending, R3 complete flag and clear on read
        step(0, 1, 0, 8'h10, 32'h8, "R2");
        idle(2);
        rd(8'h14, "R2");
        step(1, 0, 0, 8'h00, 0, "R2");
        rd(8'h14, "R3");
        rd(8'h14, "R3");

        // R7 enabled but seconds never written: no counting
        ticks(4, "R7");
        rd(8'h04, "R7");

        // R6 load seconds and count
        wr(8'h00, 32'd100);
        ticks(5, "R6");
        rd(8'h00, "R6"); rd(8'h04, "R6");
        wr(8'h04, 32'h7FFE);
        ticks(3, "R6");
        rd(8'h00, "R6"); rd(8'h04, "R6");

        // R4 back-to-back writes: second dropped, error flag
        step(0, 1, 0, 8'h08, 32'd7, "R4");
        step(0, 1, 0, 8'h0C, 32'h55, "R4");
        rd(8'h14, "R4");
        step(1, 0, 0, 8'h00, 0, "R4");
        rd(8'h08, "R4"); rd(8'h0C, "R4");

        // R5 enable word, immediate and masked
        step(0, 1, 0, 8'h18, 32'hFFFF_FFFF, "R5");
        rd(8'h18, "R5");
        rd(8'h14, "R5");
        // R9 clear write error by write-one
        wr(8'h14, 32'h80);
        rd(8'h14, "R9");

        // R8 alarm: reload counter and arm alarm slightly ahead
        step(0, 1, 0, 8'h18, 32'h10, "R5");
        wr(8'h10, 32'h0);
        wr(8'h00, 32'd200);
        wr(8'h04, 32'h0);
        wr(8'h08, 32'd200);
        wr(8'h0C, 32'd60);
        wr(8'h10, 32'h8);
        ticks(80, "R8");
        rd(8'h14, "R8");
        wr(8'h14, 32'h10);
        rd(8'h14, "R9");

        // R7 fail_hold freezes counter and raises violation
        step(0, 1, 0, 8'h18, 32'h1, "R5");
        fail_hold = 1'b1;
        ticks(6, "R7");
        rd(8'h04, "R7"); rd(8'h14, "R7");
        fail_hold = 1'b0;
        ticks(2, "R7");
        rd(8'h04, "R7");
        wr(8'h14, 32'h3);
        rd(8'h14, "R9");

        // R7 disable stops counting
        wr(8'h10, 32'h0);
        ticks(4, "R7");
        rd(8'h04, "R7");

        // R6 full wrap
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'h7FFF);
        wr(8'h10, 32'h8);
        ticks(2, "R6");
        rd(8'h00, "R6"); rd(8'h04, "R6");

        // R10 write-next interrupt
        step(0, 1, 0, 8'h18, 32'h200, "R10");
        idle(1);
        step(0, 1, 0, 8'h00, 32'd5, "R10");
        idle(2);
        step(1, 0, 0, 8'h00, 0, "R10");
        rd(8'h00, "R10");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule